// File: doc/BRIEF.md
# Segment Limit Load Unit

This unit carries out the checking and extraction step of a "load segment limit" operation in a protected-mode processor model. A request brings a 16-bit selector, the current privilege level, an operand-size code, a long-mode flag, and the base and limit of the descriptor table. The unit first checks that the whole 8-byte descriptor lies inside the table. If it does, the unit reads the descriptor once over a synchronous read port. It then checks the descriptor type and the privilege levels, and returns the limit as a byte count together with a zero-flag result and a write strobe for the destination register.

Requests use a valid/ready handshake. `req_ready` is high only while the unit is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high, and its inputs are captured on that edge. The result side has no back-pressure: `rsp_valid` is high for exactly one cycle and the consumer must take the result in that cycle. `req_ready` is already high again in that same cycle, so a new request can be taken on the next edge. Fetching the selector from memory and raising exceptions belong to the surrounding pipeline.

Top module: `seg_limit_unit`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, and `rsp_valid`, `rsp_we` and `mem_rd_en` are 0.
- R2: The handshake timing is fixed. The acceptance edge is the edge where `req_valid` and `req_ready` are both high. `req_ready` is 0 from that edge until the response. `rsp_valid` is high for exactly the one cycle that follows the second edge after acceptance, and it is low at all other times.
- R3: The read port behaves as follows:
  - In the cycle right after acceptance, `mem_rd_en` is 1 for one cycle, and only when the bound check of R4 passes.
  - `mem_rd_addr` is `tbl_base` + 8 × `req_sel[15:3]`.
  - Selector bit 2 has no effect on anything.
  - `mem_rd_data` must be valid one cycle after `mem_rd_en`.
- R4: The bound check fails when 8 × `req_sel[15:3]` + 7 > `tbl_limit`. On a bound failure, no read is issued and the result is a failure.
- R5: The 20-bit raw limit is assembled as follows: bits 15:0 come from `mem_rd_data[15:0]`, and bits 19:16 come from `mem_rd_data[51:48]`.
- R6: The granularity flag is `mem_rd_data[55]`. When it is 1, the byte limit is the raw limit shifted left by 12 with its low 12 bits set to one. When it is 0, the byte limit is the raw limit.
- R7: The operand-size code sets how much of the 32-bit byte limit reaches `rsp_limit`:
  - `req_opsize` = 0 (16-bit): only the low 16 bits, with all other bits 0.
  - Codes 1 (32-bit), 2 (64-bit) and 3: the whole 32-bit limit, zero-extended.
- R8: When the long-mode flag is 0, a system descriptor (S = `mem_rd_data[44]` = 0) is type-valid only for types 1, 2, 3, 9 and 11. The type is `mem_rd_data[43:40]`.
- R9: When the long-mode flag is 1, a system descriptor is type-valid only for types 0, 2, 9 and 11.
- R10: Descriptors with S = 1 are always type-valid. The privilege check works as follows:
  - DPL is `mem_rd_data[46:45]` and RPL is `req_sel[1:0]`.
  - The check fails when CPL > DPL or RPL > DPL.
  - A conforming code segment (S = 1 and type bits 3 and 2 both 1) skips the check.
- R11: The result passes only when the bound, type and privilege checks all pass. On a pass, `rsp_zf` and `rsp_we` are 1 with `rsp_valid`. On a failure, both are 0 and `rsp_limit` is 0. `rsp_we` is never high without `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_sel | input | SEL_W (16) | Segment selector |
| req_cpl | input | 2 | Current privilege level |
| req_opsize | input | 2 | Operand size code: 0 = 16, 1 = 32, 2 = 64 bits |
| req_long_mode | input | 1 | 1 selects the long-mode system type table |
| tbl_base | input | ADDR_W (32) | Descriptor table base address |
| tbl_limit | input | TLIM_W (16) | Descriptor table limit (last valid byte offset) |
| mem_rd_en | output | 1 | Descriptor read strobe |
| mem_rd_addr | output | ADDR_W (32) | Descriptor byte address |
| mem_rd_data | input | 64 | Descriptor, valid one cycle after the strobe |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_zf | output | 1 | Zero-flag result |
| rsp_we | output | 1 | Destination register write strobe |
| rsp_limit | output | DEST_W (64) | Byte limit for the destination |

## Verification
The assertions assume the following about the environment:
- Reset is asynchronous and held for at least one edge.
- The memory answers every strobe with data exactly one cycle later.

The latency and pulse properties only hold under this one-cycle read contract. The bench memory model is a registered lookup that always answers in one cycle. The bench raises `req_valid` only after it has seen `req_ready` high at a falling edge, and it drops `req_valid` right after the acceptance edge. The operand-size property is expressed only for code 0. The remaining size codes are covered by the bench's reference model.

// File: rtl/seg_lim_pkg.sv
package seg_lim_pkg;

  typedef enum logic [1:0] {
    SZ16  = 2'd0,
    SZ32  = 2'd1,
    SZ64  = 2'd2,
    SZRSV = 2'd3
  } opsz_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EVAL = 2'd2
  } unit_st_e;

  typedef struct packed {
    logic [19:0] raw_lim;
    logic        gran;
    logic        code_data;
    logic [3:0]  typ;
    logic [1:0]  dpl;
  } desc_fields_t;

  // one bit per system type, set where the type is accepted
  localparam logic [15:0] SYS_OK_LEGACY = 16'h0A0E;
  localparam logic [15:0] SYS_OK_LONG   = 16'h0A05;

  localparam int DESC_BYTES = 8;
  localparam int DESC_W     = 64;

endpackage

// File: rtl/sll_sel_bound.sv
module sll_sel_bound #(
  parameter int SEL_W  = 16,
  parameter int TLIM_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [TLIM_W-1:0] tbl_limit,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              in_bounds,
  output logic [1:0]        rpl
);
  import seg_lim_pkg::*;

  localparam int IDX_W = SEL_W - 3;
  localparam int OFF_W = SEL_W;
  localparam int CMP_W = (OFF_W + 1 > TLIM_W) ? OFF_W + 1 : TLIM_W;

  logic [IDX_W-1:0] index;
  logic [OFF_W-1:0] offset;
  logic [CMP_W-1:0] last_byte;
  logic [CMP_W-1:0] lim_ext;
  logic             unused_ti;

  assign index     = sel[SEL_W-1:3];
  assign unused_ti = sel[2];
  assign rpl       = sel[1:0];
  assign offset    = {index, 3'b000};
  assign last_byte = CMP_W'(offset) + CMP_W'(DESC_BYTES - 1);
  assign lim_ext   = CMP_W'(tbl_limit);
  assign in_bounds = (last_byte <= lim_ext);
  assign rd_addr   = tbl_base + ADDR_W'(offset);

endmodule

// File: rtl/sll_desc_dec.sv
module sll_desc_dec (
  input  logic [seg_lim_pkg::DESC_W-1:0] desc,
  output seg_lim_pkg::desc_fields_t      fields
);
  import seg_lim_pkg::*;

  logic unused_bits;

  always_comb begin
    fields.raw_lim   = {desc[51:48], desc[15:0]};
    fields.gran      = desc[55];
    fields.code_data = desc[44];
    fields.typ       = desc[43:40];
    fields.dpl       = desc[46:45];
  end

  assign unused_bits = ^{desc[63:56], desc[54:52], desc[47], desc[39:16]};

endmodule

// File: rtl/sll_access_chk.sv
module sll_access_chk (
  input  seg_lim_pkg::desc_fields_t fields,
  input  logic [1:0]                cpl,
  input  logic [1:0]                rpl,
  input  logic                      long_mode,
  output logic                      type_ok,
  output logic                      priv_ok
);
  import seg_lim_pkg::*;

  logic [15:0] sys_mask;
  logic        conforming;

  assign sys_mask   = long_mode ? SYS_OK_LONG : SYS_OK_LEGACY;
  assign type_ok    = fields.code_data | sys_mask[fields.typ];
  assign conforming = fields.code_data & fields.typ[3] & fields.typ[2];
  assign priv_ok    = conforming | ((cpl <= fields.dpl) & (rpl <= fields.dpl));

endmodule

// File: rtl/sll_limit_fmt.sv
module sll_limit_fmt #(
  parameter int DEST_W = 64
) (
  input  logic [19:0]       raw_lim,
  input  logic              gran,
  input  logic [1:0]        opsize,
  output logic [DEST_W-1:0] dest
);
  import seg_lim_pkg::*;

  localparam int BYTE_LIM_W = 32;

  logic [BYTE_LIM_W-1:0] byte_lim;

  assign byte_lim = gran ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};

  always_comb begin
    if (opsz_e'(opsize) == SZ16) dest = DEST_W'(byte_lim[15:0]);
    else                         dest = DEST_W'(byte_lim);
  end

endmodule

// File: rtl/seg_limit_unit.sv
module seg_limit_unit #(
  parameter int SEL_W  = 16,
  parameter int TLIM_W = 16,
  parameter int ADDR_W = 32,
  parameter int DEST_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [1:0]        req_cpl,
  input  logic [1:0]        req_opsize,
  input  logic              req_long_mode,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [TLIM_W-1:0] tbl_limit,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [63:0]       mem_rd_data,
  output logic              rsp_valid,
  output logic              rsp_zf,
  output logic              rsp_we,
  output logic [DEST_W-1:0] rsp_limit
);
  import seg_lim_pkg::*;

  unit_st_e          state;
  logic [SEL_W-1:0]  sel_q;
  logic [1:0]        cpl_q;
  logic [1:0]        size_q;
  logic              lm_q;
  logic [ADDR_W-1:0] base_q;
  logic [TLIM_W-1:0] tlim_q;
  logic              bound_q;

  logic              in_bounds;
  logic [1:0]        rpl;
  logic [ADDR_W-1:0] rd_addr;
  desc_fields_t      fields;
  logic              type_ok;
  logic              priv_ok;
  logic [DEST_W-1:0] fmt_lim;
  logic              pass;

  sll_sel_bound #(.SEL_W(SEL_W), .TLIM_W(TLIM_W), .ADDR_W(ADDR_W)) u_bound (
    .sel       (sel_q),
    .tbl_base  (base_q),
    .tbl_limit (tlim_q),
    .rd_addr   (rd_addr),
    .in_bounds (in_bounds),
    .rpl       (rpl)
  );

  sll_desc_dec u_dec (
    .desc   (mem_rd_data),
    .fields (fields)
  );

  sll_access_chk u_acc (
    .fields    (fields),
    .cpl       (cpl_q),
    .rpl       (rpl),
    .long_mode (lm_q),
    .type_ok   (type_ok),
    .priv_ok   (priv_ok)
  );

  sll_limit_fmt #(.DEST_W(DEST_W)) u_fmt (
    .raw_lim (fields.raw_lim),
    .gran    (fields.gran),
    .opsize  (size_q),
    .dest    (fmt_lim)
  );

  assign req_ready   = (state == ST_IDLE);
  assign mem_rd_en   = (state == ST_READ) & in_bounds;
  assign mem_rd_addr = rd_addr;
  assign pass        = bound_q & type_ok & priv_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sel_q     <= '0;
      cpl_q     <= '0;
      size_q    <= '0;
      lm_q      <= 1'b0;
      base_q    <= '0;
      tlim_q    <= '0;
      bound_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_zf    <= 1'b0;
      rsp_we    <= 1'b0;
      rsp_limit <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_we    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            sel_q  <= req_sel;
            cpl_q  <= req_cpl;
            size_q <= req_opsize;
            lm_q   <= req_long_mode;
            base_q <= tbl_base;
            tlim_q <= tbl_limit;
            state  <= ST_READ;
          end
        end
        ST_READ: begin
          bound_q <= in_bounds;
          state   <= ST_EVAL;
        end
        ST_EVAL: begin
          rsp_valid <= 1'b1;
          rsp_zf    <= pass;
          rsp_we    <= pass;
          rsp_limit <= pass ? fmt_lim : '0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sll_checker.sv
module sll_checker #(
  parameter int DEST_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_opsize,
  input logic              mem_rd_en,
  input logic              rsp_valid,
  input logic              rsp_zf,
  input logic              rsp_we,
  input logic [DEST_W-1:0] rsp_limit
);

  // R2: a taken request makes the unit busy
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2: the result follows two edges after acceptance
  a_r2_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##2 rsp_valid);

  // R2: single-cycle result pulse
  a_r2_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3: one read strobe per request
  a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R3: no read while idle
  a_r3_read_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);

  // R7: 16-bit size leaves upper bits clear
  a_r7_size16_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_opsize == 2'd0) |=> ##2 (rsp_limit[DEST_W-1:16] == '0));

  // R11: write strobe only with a passing valid result
  a_r11_we_needs_zf: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_we |-> (rsp_valid && rsp_zf));

  // R11: a failing result carries a zero limit and no write
  a_r11_fail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_zf) |-> (rsp_limit == '0 && !rsp_we));

endmodule

bind seg_limit_unit sll_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_opsize (req_opsize),
  .mem_rd_en  (mem_rd_en),
  .rsp_valid  (rsp_valid),
  .rsp_zf     (rsp_zf),
  .rsp_we     (rsp_we),
  .rsp_limit  (rsp_limit)
);

// File: tb/seg_limit_unit_test.sv
`timescale 1ns/1ps
module seg_limit_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_sel = '0;
  logic [1:0]  req_cpl = '0;
  logic [1:0]  req_opsize = '0;
  logic        req_long_mode = 1'b0;
  logic [31:0] tbl_base = 32'h0000_4000;
  logic [15:0] tbl_limit = 16'hFFFF;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic [63:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic        rsp_zf;
  logic        rsp_we;
  logic [63:0] rsp_limit;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit chk_on = 1'b0;
  bit finished = 1'b0;

  typedef struct {
    int          at;
    bit          rd;
    logic [31:0] addr;
    bit          zf;
    logic [63:0] lim;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [63:0] dmem [logic [31:0]];

  always #2 clk = ~clk;

  seg_limit_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_cpl(req_cpl), .req_opsize(req_opsize),
    .req_long_mode(req_long_mode), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_zf(rsp_zf), .rsp_we(rsp_we), .rsp_limit(rsp_limit)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) mem_rd_data <= dmem.exists(mem_rd_addr) ? dmem[mem_rd_addr] : 64'h0;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // per-clock comparison against the queued expectations
  always @(negedge clk) begin
    if (chk_on) begin
      bit exp_rv;
      bit exp_rd;
      logic [31:0] exp_addr;
      exp_rv = 1'b0; exp_rd = 1'b0; exp_addr = '0;
      if (q.size() > 0) begin
        exp_rd   = q[0].rd && (q[0].at - 2 == cyc);
        exp_addr = q[0].addr;
        exp_rv   = (q[0].at == cyc);
      end
      check(mem_rd_en == exp_rd, (q.size() > 0) ? q[0].tag : "R3", "R3 read strobe",
            64'(mem_rd_en), 64'(exp_rd));
      if (exp_rd)
        check(mem_rd_addr == exp_addr, q[0].tag, "R3 read address", 64'(mem_rd_addr), 64'(exp_addr));
      check(rsp_valid == exp_rv, "R2", "response pulse timing", 64'(rsp_valid), 64'(exp_rv));
      if (exp_rv) begin
        check(rsp_zf == q[0].zf, q[0].tag, "R11 zf", 64'(rsp_zf), 64'(q[0].zf));
        check(rsp_we == q[0].zf, q[0].tag, "R11 write strobe", 64'(rsp_we), 64'(q[0].zf));
        check(rsp_limit == q[0].lim, q[0].tag, "limit", rsp_limit, q[0].lim);
        void'(q.pop_front());
      end else begin
        check(!rsp_we, "R11", "write strobe without valid", 64'(rsp_we), 64'h0);
      end
    end
  end

  // behavioural reference for one request
  task automatic ref_eval(input logic [63:0] d, input logic [15:0] sel, input int cpl,
                          input int sz, input bit lm, input int tlim,
                          output bit rd, output bit zf, output logic [63:0] lim);
    int idx, last, typ, dpl, rpl;
    longint rawl, full;
    bit s, g, tok, pok;
    idx  = int'(sel) / 8;
    last = idx * 8 + 7;
    rawl = longint'(d[15:0]) + 65536 * longint'(d[51:48]);
    g    = d[55];
    s    = d[44];
    typ  = int'(d[43:40]);
    dpl  = int'(d[46:45]);
    rpl  = int'(sel) % 4;
    full = g ? rawl * 4096 + 4095 : rawl;
    if (s)       tok = 1'b1;
    else if (lm) tok = (typ == 0 || typ == 2 || typ == 9 || typ == 11);
    else         tok = (typ == 1 || typ == 2 || typ == 3 || typ == 9 || typ == 11);
    pok = (s && typ >= 12) || (cpl <= dpl && rpl <= dpl);
    rd  = (last <= tlim);
    zf  = rd && tok && pok;
    if (!zf)         lim = '0;
    else if (sz == 0) lim = 64'(full % 65536);
    else             lim = 64'(full);
  endtask

  function automatic logic [63:0] mk_desc(input int raw, input bit g, input bit s,
                                          input int typ, input int dpl);
    logic [63:0] d;
    d = 64'hA5A5_0000_5A5A_0000;
    d[15:0]  = raw[15:0];
    d[51:48] = raw[19:16];
    d[55]    = g;
    d[44]    = s;
    d[43:40] = typ[3:0];
    d[46:45] = dpl[1:0];
    d[47]    = 1'b1;
    return d;
  endfunction

  task automatic run_req(input logic [15:0] sel, input int cpl, input int sz, input bit lm,
                         input logic [63:0] desc, input int tlim, input string tag);
    exp_t e;
    bit rd, zf;
    logic [63:0] lim;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    dmem[tbl_base + 32'(int'(sel) / 8 * 8)] = desc;
    req_sel = sel; req_cpl = cpl[1:0]; req_opsize = sz[1:0];
    req_long_mode = lm; tbl_limit = tlim[15:0]; req_valid = 1'b1;
    ref_eval(desc, sel, cpl, sz, lm, tlim, rd, zf, lim);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    e.at = cyc + 2; e.rd = rd; e.addr = tbl_base + 32'(int'(sel) / 8 * 8);
    e.zf = zf; e.lim = lim; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'h1);
    check(rsp_valid == 1'b0, "R1", "valid in reset", 64'(rsp_valid), 64'h0);
    check(mem_rd_en == 1'b0, "R1", "read in reset", 64'(mem_rd_en), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && rsp_we == 1'b0, "R1", "idle after reset", 64'(req_ready), 64'h1);
    chk_on = 1'b1;

    // R5 R6 R7 granularity and sizes
    for (int sz = 0; sz < 4; sz++) begin
      run_req(16'h0018, 0, sz, 0, mk_desc(20'hABCDE, 0, 1, 2, 0), 16'hFFFF, "R5");
      run_req(16'h0020, 0, sz, 0, mk_desc(20'h12345, 1, 1, 2, 0), 16'hFFFF, "R6");
      run_req(16'h0028, 0, sz, 1, mk_desc(20'hFFFFF, 1, 1, 3, 0), 16'hFFFF, "R7");
    end
    run_req(16'h0030, 0, 1, 0, mk_desc(20'h00000, 1, 1, 2, 0), 16'hFFFF, "R6");
    run_req(16'h0030, 0, 0, 0, mk_desc(20'h00000, 0, 1, 2, 0), 16'hFFFF, "R5");

    // R8 R9 all system types in both modes
    for (int t = 0; t < 16; t++) begin
      run_req(16'h0040, 0, 1, 0, mk_desc(20'h00067 + t, 0, 0, t, 3), 16'hFFFF, "R8");
      run_req(16'h0048, 0, 2, 1, mk_desc(20'h00100 + t, 1, 0, t, 3), 16'hFFFF, "R9");
    end

    // R10 privilege and conforming bypass
    run_req(16'h0052, 2, 1, 0, mk_desc(20'h00FFF, 0, 1, 2, 2), 16'hFFFF, "R10");
    run_req(16'h0052, 3, 1, 0, mk_desc(20'h00FFF, 0, 1, 2, 2), 16'hFFFF, "R10");
    run_req(16'h0053, 2, 1, 0, mk_desc(20'h00FFF, 0, 1, 2, 2), 16'hFFFF, "R10");
    run_req(16'h0053, 3, 1, 0, mk_desc(20'h00FFF, 0, 1, 12, 0), 16'hFFFF, "R10");
    run_req(16'h0053, 3, 1, 0, mk_desc(20'h00FFF, 0, 1, 14, 0), 16'hFFFF, "R10");
    run_req(16'h0053, 3, 1, 0, mk_desc(20'h00FFF, 0, 1, 10, 0), 16'hFFFF, "R10");
    run_req(16'h0050, 0, 1, 0, mk_desc(20'h00FFF, 0, 0, 9, 0), 16'hFFFF, "R10");
    run_req(16'h0051, 1, 1, 0, mk_desc(20'h00FFF, 0, 0, 9, 0), 16'hFFFF, "R10");

    // R4 table bound edges, R3 ignored table bit
    run_req(16'h0028, 0, 1, 0, mk_desc(20'h00777, 0, 1, 2, 0), 47, "R4");
    run_req(16'h0030, 0, 1, 0, mk_desc(20'h00777, 0, 1, 2, 0), 47, "R4");
    run_req(16'h0028, 0, 1, 0, mk_desc(20'h00777, 0, 1, 2, 0), 46, "R4");
    run_req(16'hFFF8, 0, 1, 0, mk_desc(20'h00555, 0, 1, 2, 0), 16'hFFFF, "R4");
    run_req(16'h002C, 0, 1, 0, mk_desc(20'h00888, 0, 1, 2, 0), 16'hFFFF, "R3");
    tbl_base = 32'h0010_0008;
    run_req(16'h0104, 0, 2, 1, mk_desc(20'h9ABCD, 1, 0, 11, 0), 16'hFFFF, "R3");

    repeat (6) @(negedge clk);
    check(q.size() == 0, "R2", "all responses seen", 64'(q.size()), 64'h0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule